// File: doc/BRIEF.md
# Bit-Serial Reconfigurable Dot-Product Engine

This block computes one signed dot product between a set of stored weights and a set of input activations. Each lane holds one weight of up to `MAXP` bits. The weights stay in place across computations, and only the activations move. For every lane, the activation arrives as a serial bit stream with one bit per clock, least significant bit first. The engine forms bitwise products with XNOR and sums them across all weight bit planes and all lanes. It then shifts that sum by the current bit position and adds it into a signed accumulator.

Weight precision and activation precision are chosen separately at each start, from 1 to 16 bits. Each bit of an operand stands for +1 or -1 scaled by its power of two, so an XNOR of two bits is their signed product. Software-free control is minimal:
- A write port loads the weights while the engine is idle.
- A start pulse launches a run.
- A single-cycle valid flag marks the finished result.

Top module: `bsdp_engine`

## Requirements
- R1: After reset, `busy`, `res_valid` and `result` are 0, and every stored weight bit is 0.
- R2: When idle, a cycle with `wr_en` high and `start` low stores `wr_data` into the lane selected by `wr_addr`. The stored value is used from the next run on.
- R3: Operand bit value 1 counts as +1 and bit value 0 counts as -1. An operand of precision P has the value sum over i<P of (bit i ? +1 : -1)·2^i. Weight bits at positions P and above are ignored.
- R4: The result equals the sum over all lanes of (activation value × weight value), as a signed two's-complement number of width `ACC_W`.
- R5: Suppose a start is accepted at clock edge t0 with activation precision P. Then `act_bits[l]` holds activation bit k of lane l at edge t0+k. `res_valid` is high only in the cycle after edge t0+P-1.
- R6: `busy` is high from the edge after an accepted start up to the edge that takes the last bit. A `start` raised while busy is ignored.
- R7: A weight write in a cycle where `busy` or `start` is high is dropped.
- R8: Requested precisions are clamped: 0 acts as 1 and values above 16 act as 16. Both precisions are captured at the accepted start, and later changes on `iprec` and `wprec` have no effect on the run.
- R9: `result` holds its value after `res_valid` until the next accepted start.
- R10: Weight precision and activation precision are independent. Any pair from 1..16 gives the product value of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | AW | Lane index for the weight write |
| wr_data | input | MAXP | Weight value to store |
| wprec | input | PW | Requested weight precision |
| iprec | input | PW | Requested activation precision |
| start | input | 1 | Launches a run; first activation bit is taken in the same cycle |
| act_bits | input | LANES | One serial activation bit per lane |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | One-cycle flag: result is final |
| result | output | ACC_W | Signed dot-product result |

## Verification
The testbench stores all-zero weights and streams all-one activations. Because zero bits count as -1, this pattern cannot be confused with a plain unsigned multiply. Random weights and activations at equal precisions 1, 4, 8 and 16 test the shift-and-add over each bit position. Mixed pairs, such as 16 against 3, show whether the weight mask and the input bit count are kept separate. All-zero and all-one operands at full width reach the largest negative-times-negative and positive products, which exercises the sign handling and the accumulator width. Some runs drive a start and a write in the middle of the computation and scramble the precision inputs. Those runs, and the runs that follow them, show whether the captured state stayed untouched.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
   // Largest precision the engine may be built for.
   localparam int BSDP_PREC_CEIL = 16;

   // Accumulator width: sign + full product magnitude + lane growth + margin.
   function automatic int acc_width(input int lanes, input int maxp);
      return 2 * maxp + $clog2(lanes) + 2;
   endfunction
endpackage

// File: rtl/bsdp_weight_bank.sv
module bsdp_weight_bank #(
   parameter int LANES = 8,
   parameter int MAXP  = 16,
   parameter int AW    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_ok,
   input  logic [AW-1:0]               wr_addr,
   input  logic [MAXP-1:0]             wr_data,
   output logic [LANES-1:0][MAXP-1:0]  wts
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wts[g] <= '0;
         end else if (wr_ok && (wr_addr == AW'(g))) begin
            wts[g] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/bsdp_lane_xnor.sv
module bsdp_lane_xnor #(
   parameter int MAXP = 16
) (
   input  logic [MAXP-1:0] w,
   input  logic            x,
   input  logic [MAXP-1:0] mask,
   output logic [MAXP-1:0] agree
);
   // A set bit marks a +1 product; masked planes contribute nothing here
   // and are also excluded from the bias in the plane summer.
   assign agree = ~(w ^ {MAXP{x}}) & mask;
endmodule

// File: rtl/bsdp_plane_sum.sv
module bsdp_plane_sum #(
   parameter int LANES = 8,
   parameter int MAXP  = 16,
   parameter int PW    = 5,
   parameter int SUM_W = 21
) (
   input  logic [LANES-1:0][MAXP-1:0] agree,
   input  logic [PW-1:0]              wp,
   output logic signed [SUM_W-1:0]    plane
);
   logic [SUM_W-1:0] pos_sum;
   logic [SUM_W-1:0] bias;

   // Sum of +/-1 terms weighted by 2^j equals 2*(agreeing weight) - (2^wp - 1),
   // per lane; the bias is shared over all lanes.
   always_comb begin
      pos_sum = '0;
      for (int l = 0; l < LANES; l++) begin
         pos_sum = pos_sum + SUM_W'(agree[l]);
      end
      bias  = SUM_W'(LANES) * ((SUM_W'(1) << wp) - SUM_W'(1));
      plane = $signed((pos_sum << 1) - bias);
   end
endmodule

// File: rtl/bsdp_sequencer.sv
module bsdp_sequencer #(
   parameter int MAXP  = 16,
   parameter int PW    = 5,
   parameter int IW    = 4,
   parameter int SUM_W = 21,
   parameter int ACC_W = 37
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [PW-1:0]           iprec,
   input  logic [PW-1:0]           wprec,
   input  logic signed [SUM_W-1:0] plane,
   output logic [PW-1:0]           wp_eff,
   output logic                    busy,
   output logic                    res_valid,
   output logic signed [ACC_W-1:0] acc
);
   logic [PW-1:0]           ip_req, wp_req, ip_q, wp_q;
   logic [IW-1:0]           idx_q, cur_idx;
   logic                    accept, last;
   logic signed [ACC_W-1:0] plane_x, term;

   always_comb begin
      ip_req = iprec;
      if (iprec == '0)               ip_req = PW'(1);
      else if (iprec > PW'(MAXP))    ip_req = PW'(MAXP);
      wp_req = wprec;
      if (wprec == '0)               wp_req = PW'(1);
      else if (wprec > PW'(MAXP))    wp_req = PW'(MAXP);

      accept  = start && !busy;
      cur_idx = busy ? idx_q : '0;
      wp_eff  = busy ? wp_q : wp_req;
      last    = busy ? (PW'(idx_q) == (ip_q - PW'(1))) : (ip_req == PW'(1));
      plane_x = ACC_W'(plane);
      term    = plane_x <<< cur_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         ip_q      <= PW'(1);
         wp_q      <= PW'(1);
         idx_q     <= '0;
         busy      <= 1'b0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (accept) begin
            acc       <= term;
            ip_q      <= ip_req;
            wp_q      <= wp_req;
            idx_q     <= IW'(1);
            busy      <= !last;
            res_valid <= last;
         end else if (busy) begin
            acc   <= acc + term;
            idx_q <= idx_q + IW'(1);
            if (last) begin
               busy      <= 1'b0;
               res_valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bsdp_engine.sv
module bsdp_engine #(
   parameter int LANES = 8,
   parameter int MAXP  = 16,
   localparam int AW    = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int PW    = $clog2(MAXP + 1),
   localparam int ACC_W = bsdp_pkg::acc_width(LANES, MAXP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [MAXP-1:0]         wr_data,
   input  logic [PW-1:0]           wprec,
   input  logic [PW-1:0]           iprec,
   input  logic                    start,
   input  logic [LANES-1:0]        act_bits,
   output logic                    busy,
   output logic                    res_valid,
   output logic signed [ACC_W-1:0] result
);
   localparam int IW    = $clog2(MAXP);
   localparam int SUM_W = MAXP + $clog2(LANES) + 2;

   if ((LANES < 1) || (MAXP < 2) || (MAXP > bsdp_pkg::BSDP_PREC_CEIL)) begin : g_bad_cfg
      $error("bsdp_engine: LANES must be >= 1 and MAXP within 2..16");
   end

   logic [LANES-1:0][MAXP-1:0] wts;
   logic [LANES-1:0][MAXP-1:0] agree;
   logic [MAXP-1:0]            mask;
   logic [PW-1:0]              wp_eff;
   logic signed [SUM_W-1:0]    plane;
   logic                       wr_ok;

   assign wr_ok = wr_en && !busy && !start;

   for (genvar j = 0; j < MAXP; j++) begin : g_mask
      assign mask[j] = (PW'(j) < wp_eff);
   end

   bsdp_weight_bank #(.LANES(LANES), .MAXP(MAXP), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (wr_ok),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wts     (wts)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_cell
      bsdp_lane_xnor #(.MAXP(MAXP)) u_cell (
         .w     (wts[l]),
         .x     (act_bits[l]),
         .mask  (mask),
         .agree (agree[l])
      );
   end

   bsdp_plane_sum #(.LANES(LANES), .MAXP(MAXP), .PW(PW), .SUM_W(SUM_W)) u_sum (
      .agree (agree),
      .wp    (wp_eff),
      .plane (plane)
   );

   bsdp_sequencer #(.MAXP(MAXP), .PW(PW), .IW(IW), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .iprec     (iprec),
      .wprec     (wprec),
      .plane     (plane),
      .wp_eff    (wp_eff),
      .busy      (busy),
      .res_valid (res_valid),
      .acc       (result)
   );
endmodule

// File: rtl/bsdp_engine_chk.sv
module bsdp_engine_chk #(
   parameter int ACC_W = 37,
   parameter int WB    = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             res_valid,
   input logic [ACC_W-1:0] result,
   input logic [WB-1:0]    wts_flat
);
   assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !start) |=> !res_valid);

   assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(busy) || $past(start)));

   assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> res_valid);

   assert_idle_at_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy);

   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || res_valid));

   assert_wr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || start) |=> $stable(wts_flat));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));
endmodule

bind bsdp_engine bsdp_engine_chk #(.ACC_W(ACC_W), .WB(LANES * MAXP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .res_valid (res_valid),
   .result    (result),
   .wts_flat  (wts)
);

// File: tb/bsdp_engine_tb_top.sv
module bsdp_engine_tb_top;
   localparam int LANES = 8;
   localparam int MAXP  = 16;
   localparam int AW    = 3;
   localparam int PW    = 5;
   localparam int ACC_W = 37;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                    rst_n;
   logic                    wr_en;
   logic [AW-1:0]           wr_addr;
   logic [MAXP-1:0]         wr_data;
   logic [PW-1:0]           wprec, iprec;
   logic                    start;
   logic [LANES-1:0]        act_bits;
   logic                    busy, res_valid;
   logic signed [ACC_W-1:0] result;

   int errors = 0;
   int checks = 0;
   logic [MAXP-1:0] wmodel [LANES];
   logic [MAXP-1:0] xs     [LANES];

   bsdp_engine #(.LANES(LANES), .MAXP(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wprec(wprec), .iprec(iprec), .start(start), .act_bits(act_bits),
      .busy(busy), .res_valid(res_valid), .result(result)
   );

   function automatic int clampp(input int v);
      if (v == 0) return 1;
      if (v > MAXP) return MAXP;
      return v;
   endfunction

   function automatic longint sval(input logic [MAXP-1:0] v, input int p);
      longint s = 0;
      for (int i = 0; i < p; i++) s += v[i] ? (longint'(1) << i) : -(longint'(1) << i);
      return s;
   endfunction

   function automatic longint model(input int wp, input int ip);
      longint s = 0;
      for (int l = 0; l < LANES; l++) s += sval(xs[l], clampp(ip)) * sval(wmodel[l], clampp(wp));
      return s;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive_bits(input int k);
      for (int l = 0; l < LANES; l++) act_bits[l] = xs[l][k];
   endtask

   task automatic wr(input int a, input logic [MAXP-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wmodel[a] = d;
   endtask

   // disturb: start and writes mid-run, plus a write together with start (R6, R7)
   task automatic run(input int ip_req, input int wp_req, input bit disturb, input string tag);
      int     ip  = clampp(ip_req);
      longint exp = model(wp_req, ip_req);
      longint held;
      @(negedge clk);
      iprec = PW'(ip_req); wprec = PW'(wp_req); start = 1'b1;
      wr_en = disturb; wr_addr = AW'(1); wr_data = ~wmodel[1];
      drive_bits(0);
      for (int k = 1; k < ip; k++) begin
         @(negedge clk);
         if (k == 1) chk(busy == 1'b1, "R6 busy during run", longint'(busy), 1);
         start = disturb && (k == 1);
         wr_en = disturb && (k == 1); wr_addr = '0; wr_data = ~wmodel[0];
         iprec = PW'($urandom); wprec = PW'($urandom);   // R8: ignored after capture
         drive_bits(k);
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      chk(res_valid == 1'b1, {"R5 valid timing ", tag}, longint'(res_valid), 1);
      chk(longint'(result) == exp, tag, longint'(result), exp);
      held = longint'(result);
      @(negedge clk);
      chk(res_valid == 1'b0, "R5 single-cycle valid", longint'(res_valid), 0);
      chk(busy == 1'b0, "R6 idle after run", longint'(busy), 0);
      repeat (2) @(negedge clk);
      chk(longint'(result) == held, "R9 result held", longint'(result), held);
   endtask

   task automatic rand_all();
      for (int l = 0; l < LANES; l++) begin
         wr(l, MAXP'($urandom));
         xs[l] = MAXP'($urandom);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R5: watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int precs [4] = '{1, 4, 8, 16};
      void'($urandom(32'h5eed_0123));
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      wprec = PW'(1); iprec = PW'(1); start = 1'b0; act_bits = '0;
      for (int l = 0; l < LANES; l++) begin wmodel[l] = '0; xs[l] = '1; end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 busy reset", longint'(busy), 0);
      chk(res_valid == 1'b0, "R1 valid reset", longint'(res_valid), 0);
      chk(result == '0, "R1 result reset", longint'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // Zero weights act as all -1: 8 * 15 * (-15)
      run(4, 4, 1'b0, "R1 zero weights after reset");
      chk(model(4, 4) == -1800, "R3 bench model sign", model(4, 4), -1800);

      for (int l = 0; l < LANES; l++) wr(l, MAXP'(l * 4097 + 3));
      for (int l = 0; l < LANES; l++) xs[l] = MAXP'($urandom);
      run(16, 16, 1'b0, "R2 written weights");

      foreach (precs[p]) begin
         for (int it = 0; it < 4; it++) begin
            rand_all();
            run(precs[p], precs[p], 1'b0, "R4 random equal precision");
         end
      end

      rand_all(); run(4, 16, 1'b0, "R10 ip4 wp16");
      rand_all(); run(16, 3, 1'b0, "R10 ip16 wp3 upper weight bits ignored R3");
      rand_all(); run(1, 16, 1'b0, "R10 ip1 wp16");
      rand_all(); run(13, 2, 1'b0, "R10 ip13 wp2");

      for (int l = 0; l < LANES; l++) begin wr(l, '0); xs[l] = '0; end
      run(16, 16, 1'b0, "R3 all-zero operands");
      for (int l = 0; l < LANES; l++) begin wr(l, '1); xs[l] = '1; end
      run(16, 16, 1'b0, "R3 all-one operands");
      for (int l = 0; l < LANES; l++) xs[l] = '0;
      run(16, 16, 1'b0, "R3 mixed-sign extremes");

      rand_all(); run(0, 31, 1'b0, "R8 clamp ip0 wp31");
      rand_all(); run(20, 0, 1'b0, "R8 clamp ip20 wp0");

      rand_all(); run(8, 8, 1'b1, "R6 start and write during run ignored");
      run(8, 8, 1'b0, "R7 weights unchanged after dropped writes");
      run(5, 11, 1'b1, "R7 disturbed run second");
      run(16, 16, 1'b0, "R7 weights unchanged final");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule